// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides whether a program, erase or status-register write may go ahead on a 512 KB serial NOR flash array. It receives each decoded command as a one-cycle strobe with an opcode class and a target byte address. It holds the write-enable latch, the seven stored status bits (five region-select bits and two lock bits) and a deep power-down flag. One clock after each strobe it answers with a grant or a refusal, which the array sequencer uses to start or drop the operation.

The protected region is decoded from the five region-select bits. With the fine-grain bit clear, the region is counted in 64 KB blocks; with it set, the region is counted in 4 KB sectors. A placement bit puts the region at the top or at the bottom of the array. A program, sector erase or block erase is refused when any byte of its aligned target range falls inside that region. A low level on the hardware write-protect input freezes all seven status bits. While the block is in deep power-down, it ignores every command except the release command.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `wel` = 0, `dpd` = 0 and `grant_valid` = 0, and `{lock_bits, prot_bits}` equals the stored value `SR_INIT` (default 7'h00).
- R2: Opcode 1 (enable writes) sets `wel` and opcode 2 (disable writes) clears it. Both are granted.
- R3: Every strobe gets exactly one response: `grant_valid` is high for one cycle, the cycle after the strobe, and `grant_ok` is valid in that same cycle.
- R4: Opcode 4 (program a 256 B page), opcode 5 (erase a 4 KB sector) and opcode 6 (erase a 64 KB block) act on the aligned range that holds `cmd_addr`. Such an operation is granted only when `wel` = 1 and the range does not overlap the protected region. A granted operation clears `wel`; a refused one leaves `wel` unchanged.
- R5: With `prot_bits[4]` = 0, a level `prot_bits[2:0]` of 1, 2 or 3 protects 64 KB, 128 KB or 256 KB, and a level of 4 to 7 protects the whole array. `prot_bits[3]` = 0 places the region at the top of the array and 1 places it at the bottom.
- R6: With `prot_bits[4]` = 1, a level of 1, 2 or 3 protects 4 KB, 8 KB or 16 KB, a level of 4, 5 or 6 protects 32 KB, and a level of 7 protects the whole array. Placement follows `prot_bits[3]` as in R5.
- R7: A level `prot_bits[2:0]` = 0 protects nothing, whatever bits 4 and 3 hold.
- R8: Opcode 7 (chip erase) is granted only when `wel` = 1 and nothing is protected. When granted, it clears `wel`.
- R9: Opcode 3 (status write) loads `sr_wdata` (bits 6:5 to `lock_bits`, bits 4:0 to `prot_bits`) and clears `wel`. This happens only when `wel` = 1 and `wp_n` = 1. Otherwise the write is refused and the status bits and `wel` are unchanged.
- R10: Opcode 8 enters deep power-down and opcode 9 leaves it. While `dpd` = 1, every other opcode is refused and changes no state. Any other opcode outside deep power-down is granted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Opcode class |
| cmd_addr | input | 19 | Target byte address |
| sr_wdata | input | 7 | Status value for a status write |
| wp_n | input | 1 | Hardware write-protect, active low |
| grant_valid | output | 1 | Response strobe |
| grant_ok | output | 1 | 1 = operation may proceed |
| wel | output | 1 | Write-enable latch |
| dpd | output | 1 | Deep power-down state |
| prot_bits | output | 5 | Region-select bits |
| lock_bits | output | 2 | Status lock bits |

## Verification
A wrong write-enable latch shows up at the very next response. A latch left set after a granted erase turns the following refused-by-latch program into a grant. A latch cleared by a refusal turns a later legal program into a denial. A wrong region decode shows up as a flipped `grant_ok` on the first operation that straddles a region edge, so the stimulus probes the bytes just inside and just outside each edge. A deep power-down flag that leaks appears as a grant or a `wel` change during power-down, again one cycle after the strobe.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W = 19,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16,
  parameter int OPC_W  = 4,
  parameter logic [6:0] SR_INIT = 7'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OPC_W-1:0]  cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [6:0]        sr_wdata,
  input  logic              wp_n,
  output logic              grant_valid,
  output logic              grant_ok,
  output logic              wel,
  output logic              dpd,
  output logic [4:0]        prot_bits,
  output logic [1:0]        lock_bits
);

  localparam int SPAN_W = ADDR_W + 1;
  localparam int LOG_W  = $clog2(SPAN_W + 1);

  localparam logic [OPC_W-1:0] OP_WEN  = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_WDIS = OPC_W'(2);
  localparam logic [OPC_W-1:0] OP_WRSR = OPC_W'(3);
  localparam logic [OPC_W-1:0] OP_PROG = OPC_W'(4);
  localparam logic [OPC_W-1:0] OP_SE   = OPC_W'(5);
  localparam logic [OPC_W-1:0] OP_BE   = OPC_W'(6);
  localparam logic [OPC_W-1:0] OP_CE   = OPC_W'(7);
  localparam logic [OPC_W-1:0] OP_DPD  = OPC_W'(8);
  localparam logic [OPC_W-1:0] OP_WAKE = OPC_W'(9);

  localparam logic [SPAN_W-1:0] ONE      = SPAN_W'(1);
  localparam logic [SPAN_W-1:0] SPAN_TOP = ONE << ADDR_W;

  logic [6:0] sr_q, sr_d;
  logic       wel_d, dpd_d, ok_d;

  assign prot_bits = sr_q[4:0];
  assign lock_bits = sr_q[6:5];

  wire [2:0] bp_lvl  = sr_q[2:0];
  wire       bp_low  = sr_q[3];
  wire       bp_fine = sr_q[4];

  logic             prot_any;
  logic [LOG_W-1:0] prot_log;

  always_comb begin
    prot_any = (bp_lvl != 3'd0);
    if (!bp_fine) begin
      if (bp_lvl[2]) prot_log = LOG_W'(ADDR_W);
      else           prot_log = LOG_W'(ADDR_W - 4) + LOG_W'(bp_lvl);
    end else begin
      if (bp_lvl == 3'd7)  prot_log = LOG_W'(ADDR_W);
      else if (bp_lvl[2])  prot_log = LOG_W'(SECT_W + 3);
      else                 prot_log = LOG_W'(SECT_W - 1) + LOG_W'(bp_lvl);
    end
  end

  wire [SPAN_W-1:0] prot_size = ONE << prot_log;
  wire [SPAN_W-1:0] prot_lo   = bp_low ? '0 : SPAN_TOP - prot_size;
  wire [SPAN_W-1:0] prot_hi   = bp_low ? prot_size - ONE : SPAN_TOP - ONE;

  logic [LOG_W-1:0] op_log;
  always_comb begin
    case (cmd_op)
      OP_PROG: op_log = LOG_W'(PAGE_W);
      OP_SE:   op_log = LOG_W'(SECT_W);
      default: op_log = LOG_W'(BLK_W);
    endcase
  end

  wire [SPAN_W-1:0] op_size = ONE << op_log;
  wire [SPAN_W-1:0] op_lo   = {1'b0, cmd_addr} & ~(op_size - ONE);
  wire [SPAN_W-1:0] op_hi   = op_lo + op_size - ONE;
  wire              hits    = prot_any && (op_lo <= prot_hi) && (op_hi >= prot_lo);

  always_comb begin
    ok_d  = 1'b0;
    wel_d = wel;
    dpd_d = dpd;
    sr_d  = sr_q;
    if (cmd_valid) begin
      if (dpd) begin
        if (cmd_op == OP_WAKE) begin
          ok_d  = 1'b1;
          dpd_d = 1'b0;
        end
      end else begin
        case (cmd_op)
          OP_WEN: begin
            ok_d  = 1'b1;
            wel_d = 1'b1;
          end
          OP_WDIS: begin
            ok_d  = 1'b1;
            wel_d = 1'b0;
          end
          OP_WRSR: if (wel && wp_n) begin
            ok_d  = 1'b1;
            sr_d  = sr_wdata;
            wel_d = 1'b0;
          end
          OP_PROG, OP_SE, OP_BE: if (wel && !hits) begin
            ok_d  = 1'b1;
            wel_d = 1'b0;
          end
          OP_CE: if (wel && !prot_any) begin
            ok_d  = 1'b1;
            wel_d = 1'b0;
          end
          OP_DPD: begin
            ok_d  = 1'b1;
            dpd_d = 1'b1;
          end
          default: ok_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_ok    <= 1'b0;
      wel         <= 1'b0;
      dpd         <= 1'b0;
      sr_q        <= SR_INIT;
    end else begin
      grant_valid <= cmd_valid;
      grant_ok    <= ok_d;
      wel         <= wel_d;
      dpd         <= dpd_d;
      sr_q        <= sr_d;
    end
  end

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
  parameter int OPC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [OPC_W-1:0] cmd_op,
  input logic [6:0]       sr_wdata,
  input logic             wp_n,
  input logic             grant_valid,
  input logic             grant_ok,
  input logic             wel,
  input logic             dpd,
  input logic [4:0]       prot_bits,
  input logic [1:0]       lock_bits
);

  wire is_write_op = (cmd_op >= OPC_W'(3)) && (cmd_op <= OPC_W'(7));

  assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> grant_valid);
  assert_no_stray_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !grant_valid);
  assert_wen_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !dpd && cmd_op == OPC_W'(1) |=> wel);
  assert_wdis_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !dpd && cmd_op == OPC_W'(2) |=> !wel);
  assert_wel_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cmd_valid && cmd_op == OPC_W'(1)));
  assert_need_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !dpd && !wel && is_write_op |=> !grant_ok);
  assert_ce_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OPC_W'(7) && prot_bits[2:0] != 3'd0 |=> !grant_ok);
  assert_wp_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !wp_n |=> $stable(prot_bits) && $stable(lock_bits));
  assert_sr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !dpd && wel && wp_n && cmd_op == OPC_W'(3)
      |=> {lock_bits, prot_bits} == $past(sr_wdata) && !wel);
  assert_dpd_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && dpd && cmd_op != OPC_W'(9)
      |=> !grant_ok && dpd && $stable(wel) && $stable(prot_bits));

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.OPC_W(OPC_W)) u_chk (.*);

// File: tb/tb_flash_wp_ctrl.sv
module tb_flash_wp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [18:0] cmd_addr = '0;
  logic [6:0]  sr_wdata = '0;
  logic        wp_n = 1'b1;
  logic        grant_valid, grant_ok, wel, dpd;
  logic [4:0]  prot_bits;
  logic [1:0]  lock_bits;

  flash_wp_ctrl dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit        ok;
    bit        wel;
    bit        dpd;
    bit [6:0]  sr;
    string     tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit m_wel = 0, m_dpd = 0;
  bit [6:0] m_sr = 7'h00;

  function automatic void region(input bit [4:0] bp, output bit any, output int lo, output int hi);
    int sz;
    any = (bp[2:0] != 0);
    sz = 0;
    if (bp[4] == 1'b0) begin
      case (bp[2:0])
        3'd1: sz = 65536;
        3'd2: sz = 131072;
        3'd3: sz = 262144;
        default: sz = 524288;
      endcase
    end else begin
      case (bp[2:0])
        3'd1: sz = 4096;
        3'd2: sz = 8192;
        3'd3: sz = 16384;
        3'd7: sz = 524288;
        default: sz = 32768;
      endcase
    end
    if (bp[3]) begin lo = 0; hi = sz - 1; end
    else begin lo = 524288 - sz; hi = 524287; end
  endfunction

  task automatic do_cmd(input bit [3:0] op, input bit [18:0] addr, input bit [6:0] data,
                        input bit wp, input string tag);
    exp_t e;
    bit any, ok;
    int lo, hi, sz, a0;
    ok = 0;
    region(m_sr[4:0], any, lo, hi);
    sz = (op == 4) ? 256 : (op == 5) ? 4096 : 65536;
    a0 = int'(addr) / sz * sz;
    if (m_dpd) begin
      if (op == 9) begin ok = 1; m_dpd = 0; end
    end else begin
      case (op)
        4'd1: begin ok = 1; m_wel = 1; end
        4'd2: begin ok = 1; m_wel = 0; end
        4'd3: if (m_wel && wp) begin ok = 1; m_sr = data; m_wel = 0; end
        4'd4, 4'd5, 4'd6:
          if (m_wel && !(any && a0 <= hi && a0 + sz - 1 >= lo)) begin ok = 1; m_wel = 0; end
        4'd7: if (m_wel && !any) begin ok = 1; m_wel = 0; end
        4'd8: begin ok = 1; m_dpd = 1; end
        default: ok = 1;
      endcase
    end
    e.ok = ok; e.wel = m_wel; e.dpd = m_dpd; e.sr = m_sr; e.tag = tag;
    @(negedge clk);
    q.push_back(e);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; sr_wdata = data; wp_n = wp;
    @(negedge clk);
    cmd_valid = 1'b0; wp_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n && grant_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R3: response with no command, got grant_ok=%0b expected none", grant_ok);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (grant_ok !== e.ok || wel !== e.wel || dpd !== e.dpd || {lock_bits, prot_bits} !== e.sr) begin
          fails++;
          $display("FAIL %s: ok/wel/dpd/sr got %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                   e.tag, grant_ok, wel, dpd, {lock_bits, prot_bits}, e.ok, e.wel, e.dpd, e.sr);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic wrsr(input bit [6:0] v, input string tag);
    do_cmd(4'd1, '0, '0, 1'b1, "R2");
    do_cmd(4'd3, '0, v, 1'b1, tag);
  endtask

  task automatic try_op(input bit [3:0] op, input bit [18:0] addr, input string tag);
    do_cmd(4'd1, '0, '0, 1'b1, "R2");
    do_cmd(op, addr, '0, 1'b1, tag);
    do_cmd(4'd2, '0, '0, 1'b1, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (wel !== 0 || dpd !== 0 || grant_valid !== 0 || {lock_bits, prot_bits} !== 7'h00) begin
      fails++;
      $display("FAIL R1: wel/dpd/gv/sr got %0b/%0b/%0b/%h expected 0/0/0/00",
               wel, dpd, grant_valid, {lock_bits, prot_bits});
    end
    do_cmd(4'd1, '0, '0, 1'b1, "R2");
    do_cmd(4'd2, '0, '0, 1'b1, "R2");
    do_cmd(4'd4, 19'h00100, '0, 1'b1, "R4");
    do_cmd(4'd1, '0, '0, 1'b1, "R2");
    do_cmd(4'd3, '0, 7'h01, 1'b0, "R9");
    do_cmd(4'd3, '0, 7'h01, 1'b1, "R9");
    do_cmd(4'd3, '0, 7'h00, 1'b1, "R9");
    try_op(4'd4, 19'h6FF00, "R5");
    try_op(4'd5, 19'h70000, "R4");
    try_op(4'd6, 19'h60000, "R5");
    try_op(4'd7, 19'h00000, "R8");
    wrsr(7'h0A, "R9");
    try_op(4'd5, 19'h1F000, "R5");
    try_op(4'd5, 19'h20000, "R5");
    wrsr(7'h03, "R9");
    try_op(4'd6, 19'h30000, "R5");
    try_op(4'd6, 19'h40000, "R5");
    wrsr(7'h04, "R9");
    try_op(4'd4, 19'h00000, "R5");
    wrsr(7'h11, "R9");
    try_op(4'd5, 19'h7E000, "R6");
    try_op(4'd4, 19'h7F000, "R6");
    wrsr(7'h1D, "R9");
    try_op(4'd5, 19'h07000, "R6");
    try_op(4'd5, 19'h08000, "R6");
    wrsr(7'h13, "R9");
    try_op(4'd5, 19'h7B000, "R6");
    try_op(4'd5, 19'h7C000, "R6");
    wrsr(7'h1A, "R9");
    try_op(4'd4, 19'h01F00, "R6");
    try_op(4'd4, 19'h02000, "R6");
    wrsr(7'h17, "R9");
    try_op(4'd5, 19'h40000, "R6");
    wrsr(7'h18, "R9");
    try_op(4'd7, 19'h00000, "R7");
    wrsr(7'h68, "R7");
    try_op(4'd5, 19'h00000, "R7");
    do_cmd(4'd8, '0, '0, 1'b1, "R10");
    do_cmd(4'd1, '0, '0, 1'b1, "R10");
    do_cmd(4'd3, '0, 7'h05, 1'b1, "R10");
    do_cmd(4'd10, '0, '0, 1'b1, "R10");
    do_cmd(4'd9, '0, '0, 1'b1, "R10");
    do_cmd(4'd9, '0, '0, 1'b1, "R10");
    do_cmd(4'd10, '0, '0, 1'b1, "R10");
    do_cmd(4'd1, '0, '0, 1'b1, "R2");
    do_cmd(4'd8, '0, '0, 1'b1, "R10");
    do_cmd(4'd2, '0, '0, 1'b1, "R10");
    do_cmd(4'd9, '0, '0, 1'b1, "R10");
    do_cmd(4'd4, 19'h00000, '0, 1'b1, "R4");
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3: pending responses got %0d expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule